// File: doc/BRIEF.md
# Windowed Independent Watchdog

This block is a watchdog timer whose 12-bit down-counter runs on a slow, free-running clock that is separate from the bus clock. The slow clock first passes through a prescaler. The prescaler divides by 4 up to 256, depending on a 3-bit code. A small register bank on the bus clock holds the settings: a prescaler code, a reload value, a window value, three busy flags and a key register.

Software protects the settings and commands the watchdog by writing key codes. One code opens the settings for writing. One code starts the counter, and once started it cannot be stopped. One code refreshes the counter. A refresh must come inside the window, that is, while the counter is at or below the window value. A refresh that comes earlier pulses the reset output, and so does the counter running out.

Each new setting is carried into the slow domain by a toggle handshake. While the transfer is in flight, a busy flag for that setting is raised, and the setting cannot be rewritten.

Top module: `wdg_top`

## Requirements
- R1: After reset, the registers at offsets 0x04, 0x08, 0x0C and 0x10 all read 0, and the reset output `wdg_rst_o` is low.
- R2: The key register sits at offset 0x00 and takes the key in write data bits [15:0]. It always reads back 0.
- R3: The prescaler code sits in bits [2:0] at offset 0x04. The reload value sits in bits [11:0] at 0x08, and the window value in bits [11:0] at 0x10. Each reads back the written value once its transfer has completed. A prescaler read returns the value held in the slow domain.
- R4: A write to 0x04, 0x08 or 0x10 takes effect only if the most recent key write was 0x5555. A key write of any other value locks the registers again.
- R5: The status register sits at 0x0C. Bit 0 flags the prescaler transfer, bit 1 the reload transfer and bit 2 the window transfer. A flag reads 1 from the bus cycle after an accepted write. It returns to 0 within five slow-clock cycles.
- R6: A write to a setting whose busy flag is set is ignored.
- R7: Key 0xCCCC starts the watchdog, and the counter loads the reload value. No later key write stops it; only a reset does.
- R8: The counter steps down once per prescaler period of 4·2^code slow cycles, and code 7 gives 256. A step taken while the counter is at 0 pulses `wdg_rst_o` high for one slow cycle and reloads the counter. A running watchdog that is never refreshed therefore pulses every (reload+1)·period slow cycles.
- R9: Key 0xAAAA written while the counter is at or below the window value reloads the counter and does not pulse the reset.
- R10: Key 0xAAAA written while the counter is above the window value pulses `wdg_rst_o` for one slow cycle and reloads the counter.
- R11: Key 0xAAAA written before the watchdog is started has no effect, and no reset pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| lsi_clk | input | 1 | Slow counter clock |
| bus_wr | input | 1 | Write strobe, taken on the rising edge of clk |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wdg_rst_o | output | 1 | Reset request, one slow-clock cycle wide, in the slow domain |

## Verification
Each result is due at a known time:
- **Busy flag set:** due at the bus cycle after the write, so the bench reads status at the very next falling edge.
- **Busy flag clear:** due within five slow cycles. The bench polls status once per bus cycle and counts the slow-clock edges that pass before the flag drops.
- **Reset pulses:** the synchronizers make the first pulse land a few slow cycles late, so the first pulse is checked against a small band. The spacing between later pulses is exact in slow cycles, and the bench compares it with (reload+1)·period.
- **Refresh checks:** each refresh is placed many prescaler periods away from its window edge. The reset output is sampled on the falling edge of the slow clock.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 5;
  localparam int KEY_W   = 16;
  localparam int CNT_W   = 12;
  localparam int PR_W    = 3;
  localparam int PCNT_W  = 8;
  localparam int NUM_CFG = 3;

  // channel indices of the transferred settings (status bit order)
  localparam int CH_PR = 0;
  localparam int CH_RL = 1;
  localparam int CH_WN = 2;

  localparam logic [ADDR_W-1:0] OFS_KEY = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_PR  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_RL  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_ST  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_WN  = 5'h10;

  localparam logic [KEY_W-1:0] KEY_OPEN    = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_RUN     = 16'hCCCC;
  localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;

  typedef logic [CNT_W-1:0] cfg_word_t;

  // last prescaler count before a tick: divider 4<<code, saturating at 256
  function automatic logic [PCNT_W-1:0] presc_limit(input logic [PR_W-1:0] code);
    logic [PR_W-1:0] sh;
    logic [PCNT_W:0] div;
    sh  = (code > 3'd6) ? 3'd6 : code;
    div = (PCNT_W+1)'(4) << sh;
    return PCNT_W'(div - 1'b1);
  endfunction

  // which setting an address selects, one-hot
  function automatic logic [NUM_CFG-1:0] cfg_hit(input logic [ADDR_W-1:0] a);
    logic [NUM_CFG-1:0] h;
    h        = '0;
    h[CH_PR] = (a == OFS_PR);
    h[CH_RL] = (a == OFS_RL);
    h[CH_WN] = (a == OFS_WN);
    return h;
  endfunction

  // field of the write data a given setting keeps
  function automatic cfg_word_t cfg_field(input int ch, input logic [DATA_W-1:0] d);
    if (ch == CH_PR) return cfg_word_t'(d[PR_W-1:0]);
    return d[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/wdg_sync2.sv
module wdg_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/wdg_xfer.sv
// One setting carried from the bus clock to the slow clock by a toggle
// handshake; busy stays high from the load until the acknowledge returns.
module wdg_xfer #(
  parameter int W = 12
) (
  input  logic         bclk,
  input  logic         sclk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         busy,
  output logic [W-1:0] shadow,
  output logic [W-1:0] dout
);
  logic req_tgl, ack_tgl, ack_b, req_s;

  // bus side
  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      req_tgl <= 1'b0;
      shadow  <= '0;
    end else if (load) begin
      req_tgl <= ~req_tgl;
      shadow  <= din;
    end
  end

  wdg_sync2 u_ack_sync (.clk(bclk), .rst_n(rst_n), .d(ack_tgl), .q(ack_b));
  assign busy = req_tgl ^ ack_b;

  // slow side: shadow is held still while busy, so it is safe to sample
  wdg_sync2 u_req_sync (.clk(sclk), .rst_n(rst_n), .d(req_tgl), .q(req_s));

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      ack_tgl <= 1'b0;
      dout    <= '0;
    end else if (req_s != ack_tgl) begin
      ack_tgl <= req_s;
      dout    <= shadow;
    end
  end
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic [NUM_CFG-1:0]          cfg_busy,
  input  cfg_word_t [NUM_CFG-1:0]     cfg_shadow,
  input  logic [PR_W-1:0]             pr_slow,
  output logic [NUM_CFG-1:0]          cfg_try,
  output logic [NUM_CFG-1:0]          cfg_load,
  output cfg_word_t [NUM_CFG-1:0]     cfg_wdata,
  output logic                        unlocked,
  output logic                        run_q,
  output logic                        refresh_tgl
);
  logic             key_wr;
  logic [KEY_W-1:0] key_val;
  logic [NUM_CFG-1:0] hit;
  logic             unused_wdata_hi;

  assign key_wr          = bus_wr && (bus_addr == OFS_KEY);
  assign key_val         = bus_wdata[KEY_W-1:0];
  assign hit             = cfg_hit(bus_addr);
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:KEY_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked    <= 1'b0;
      run_q       <= 1'b0;
      refresh_tgl <= 1'b0;
    end else if (key_wr) begin
      unlocked <= (key_val == KEY_OPEN);
      if (key_val == KEY_RUN)     run_q       <= 1'b1;
      if (key_val == KEY_REFRESH) refresh_tgl <= ~refresh_tgl;
    end
  end

  for (genvar ch = 0; ch < NUM_CFG; ch++) begin : g_cfg
    assign cfg_try[ch]   = bus_wr && hit[ch];
    assign cfg_load[ch]  = cfg_try[ch] && unlocked && !cfg_busy[ch];
    assign cfg_wdata[ch] = cfg_field(ch, bus_wdata);
  end

  always_comb begin
    unique case (bus_addr)
      OFS_PR:  bus_rdata = DATA_W'(pr_slow);
      OFS_RL:  bus_rdata = DATA_W'(cfg_shadow[CH_RL]);
      OFS_WN:  bus_rdata = DATA_W'(cfg_shadow[CH_WN]);
      OFS_ST:  bus_rdata = DATA_W'(cfg_busy);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdg_core.sv
// Slow-domain prescaler, down-counter and reset pulse generation.
module wdg_core
  import wdg_pkg::*;
(
  input  logic            sclk,
  input  logic            rst_n,
  input  logic            run_req,
  input  logic            refresh_tgl,
  input  logic [PR_W-1:0] pr_code,
  input  cfg_word_t       reload_val,
  input  cfg_word_t       window_val,
  output logic            wdg_rst,
  output logic            run_s,
  output logic            refresh_evt,
  output logic            early_evt,
  output logic            expire_evt
);
  logic              run_d, ref_s, ref_d;
  logic              start_evt, tick;
  logic [PCNT_W-1:0] pcnt, plim;
  cfg_word_t         cnt;

  wdg_sync2 u_run_sync (.clk(sclk), .rst_n(rst_n), .d(run_req),     .q(run_s));
  wdg_sync2 u_ref_sync (.clk(sclk), .rst_n(rst_n), .d(refresh_tgl), .q(ref_s));

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      run_d <= 1'b0;
      ref_d <= 1'b0;
    end else begin
      run_d <= run_s;
      ref_d <= ref_s;
    end
  end

  assign start_evt   = run_s & ~run_d;
  assign refresh_evt = run_s & ~start_evt & (ref_s ^ ref_d);
  assign plim        = presc_limit(pr_code);
  assign tick        = run_s & ~start_evt & ~refresh_evt & (pcnt >= plim);
  assign early_evt   = refresh_evt & (cnt > window_val);
  assign expire_evt  = tick & (cnt == '0);

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pcnt <= '0;
    end else if (start_evt || refresh_evt) begin
      cnt  <= reload_val;
      pcnt <= '0;
    end else if (tick) begin
      pcnt <= '0;
      cnt  <= (cnt == '0) ? reload_val : cnt - 1'b1;
    end else if (run_s) begin
      pcnt <= pcnt + 1'b1;
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) wdg_rst <= 1'b0;
    else        wdg_rst <= early_evt | expire_evt;
  end
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lsi_clk,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdg_rst_o
);
  logic [NUM_CFG-1:0]      cfg_try, cfg_load, cfg_busy;
  cfg_word_t [NUM_CFG-1:0] cfg_wdata, cfg_shadow, cfg_slow;
  logic                    unlocked, run_q, refresh_tgl;
  logic                    run_s, refresh_evt, early_evt, expire_evt;
  logic                    unused_pr_hi;

  wdg_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cfg_busy   (cfg_busy),
    .cfg_shadow (cfg_shadow),
    .pr_slow    (cfg_slow[CH_PR][PR_W-1:0]),
    .cfg_try    (cfg_try),
    .cfg_load   (cfg_load),
    .cfg_wdata  (cfg_wdata),
    .unlocked   (unlocked),
    .run_q      (run_q),
    .refresh_tgl(refresh_tgl)
  );

  for (genvar ch = 0; ch < NUM_CFG; ch++) begin : g_xfer
    wdg_xfer #(.W(CNT_W)) u_xfer (
      .bclk  (clk),
      .sclk  (lsi_clk),
      .rst_n (rst_n),
      .load  (cfg_load[ch]),
      .din   (cfg_wdata[ch]),
      .busy  (cfg_busy[ch]),
      .shadow(cfg_shadow[ch]),
      .dout  (cfg_slow[ch])
    );
  end

  assign unused_pr_hi = ^{cfg_slow[CH_PR][CNT_W-1:PR_W], cfg_shadow[CH_PR]};

  wdg_core u_core (
    .sclk       (lsi_clk),
    .rst_n      (rst_n),
    .run_req    (run_q),
    .refresh_tgl(refresh_tgl),
    .pr_code    (cfg_slow[CH_PR][PR_W-1:0]),
    .reload_val (cfg_slow[CH_RL]),
    .window_val (cfg_slow[CH_WN]),
    .wdg_rst    (wdg_rst_o),
    .run_s      (run_s),
    .refresh_evt(refresh_evt),
    .early_evt  (early_evt),
    .expire_evt (expire_evt)
  );
endmodule

// File: rtl/wdg_top_chk.sv
module wdg_top_chk
  import wdg_pkg::*;
(
  input logic                    clk,
  input logic                    lsi_clk,
  input logic                    rst_n,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [DATA_W-1:0]       bus_rdata,
  input logic [NUM_CFG-1:0]      cfg_try,
  input logic [NUM_CFG-1:0]      cfg_load,
  input logic [NUM_CFG-1:0]      cfg_busy,
  input cfg_word_t [NUM_CFG-1:0] cfg_shadow,
  input logic                    unlocked,
  input logic                    run_q,
  input logic                    run_s,
  input logic                    early_evt,
  input logic                    expire_evt,
  input logic                    wdg_rst_o
);
  // R2
  key_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_KEY) |-> (bus_rdata == '0));

  // R5
  status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_ST) |-> (bus_rdata[DATA_W-1:NUM_CFG] == '0));

  for (genvar ch = 0; ch < NUM_CFG; ch++) begin : g_ch
    // R4
    locked_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_try[ch] && !unlocked) |=> $stable(cfg_shadow[ch]));
    // R5
    busy_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load[ch] |=> cfg_busy[ch]);
    // R6
    busy_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_try[ch] && cfg_busy[ch]) |=> $stable(cfg_shadow[ch]));
  end

  // R7
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(run_q));

  // R8
  expire_pulse_chk: assert property (@(posedge lsi_clk) disable iff (!rst_n)
    expire_evt |=> wdg_rst_o);

  // R10
  early_pulse_chk: assert property (@(posedge lsi_clk) disable iff (!rst_n)
    early_evt |=> wdg_rst_o);

  // R8
  pulse_has_cause_chk: assert property (@(posedge lsi_clk) disable iff (!rst_n)
    wdg_rst_o |-> $past(early_evt || expire_evt));

  // R11
  pulse_needs_run_chk: assert property (@(posedge lsi_clk) disable iff (!rst_n)
    (early_evt || expire_evt) |-> run_s);
endmodule

bind wdg_top wdg_top_chk u_chk (
  .clk       (clk),
  .lsi_clk   (lsi_clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .cfg_try   (cfg_try),
  .cfg_load  (cfg_load),
  .cfg_busy  (cfg_busy),
  .cfg_shadow(cfg_shadow),
  .unlocked  (unlocked),
  .run_q     (run_q),
  .run_s     (run_s),
  .early_evt (early_evt),
  .expire_evt(expire_evt),
  .wdg_rst_o (wdg_rst_o)
);

// File: tb/wdg_top_tb.sv
module wdg_top_tb;
  logic        clk = 1'b0, lsi_clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdg_rst_o;

  int checks = 0, fails = 0;
  int scyc = 0, pulses = 0, wide = 0;
  int ptime[8];
  bit prev_hi = 1'b0;

  wdg_top u_dut (
    .clk(clk), .rst_n(rst_n), .lsi_clk(lsi_clk), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdg_rst_o(wdg_rst_o)
  );

  always #10 clk = ~clk;       // 50 MHz
  always #80 lsi_clk = ~lsi_clk;

  always @(posedge lsi_clk) scyc++;
  always @(negedge lsi_clk) begin
    if (wdg_rst_o) begin
      if (pulses < 8) ptime[pulses] = scyc;
      pulses++;
      if (prev_hi) wide++;
    end
    prev_hi = wdg_rst_o;
  end

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    bus_wr = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(posedge lsi_clk);
    @(negedge clk) rst_n = 1'b1;
    pulses = 0;
    wide   = 0;
    repeat (2) @(posedge lsi_clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle(input logic [31:0] mask, output int used);
    logic [31:0] st;
    int s0;
    s0 = scyc;
    for (int i = 0; i < 400; i++) begin
      rd(5'h0C, st);
      if ((st & mask) == 0) break;
    end
    used = scyc - s0;
  endtask

  task automatic setup(input int pr, input int rl, input int wn);
    int u;
    wr(5'h00, 32'h5555);
    wr(5'h04, pr); wait_idle(1, u);
    wr(5'h08, rl); wait_idle(2, u);
    wr(5'h10, wn); wait_idle(4, u);
  endtask

  task automatic wait_pulses(input int n, input int limit);
    for (int i = 0; i < limit; i++) begin
      if (pulses >= n) break;
      @(posedge lsi_clk);
    end
  endtask

  function automatic int period_of(input int code);
    int e;
    e = code + 2;
    if (e > 8) e = 8;
    return 2 ** e;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(5'h04, d); chk("R1 prescaler after reset", d == 0, d, 0);
    rd(5'h08, d); chk("R1 reload after reset", d == 0, d, 0);
    rd(5'h0C, d); chk("R1 status after reset", d == 0, d, 0);
    rd(5'h10, d); chk("R1 window after reset", d == 0, d, 0);
    chk("R1 reset output low", wdg_rst_o == 0, wdg_rst_o, 0);
    wr(5'h00, 32'h5555);
    rd(5'h00, d); chk("R2 key reads zero", d == 0, d, 0);
  endtask

  task automatic t_protect();
    logic [31:0] d;
    int u;
    do_reset();
    wr(5'h04, 5);
    repeat (10) @(posedge lsi_clk);
    rd(5'h04, d); chk("R4 locked prescaler write", d == 0, d, 0);
    rd(5'h0C, d); chk("R4 no transfer when locked", d == 0, d, 0);
    wr(5'h00, 32'h5555); wr(5'h00, 32'h1234);
    wr(5'h08, 32'h123);
    repeat (10) @(posedge lsi_clk);
    rd(5'h08, d); chk("R4 relocked by other key", d == 0, d, 0);
    wr(5'h00, 32'h5555); wr(5'h00, 32'hAAAA);
    wr(5'h10, 32'h77);
    repeat (10) @(posedge lsi_clk);
    rd(5'h10, d); chk("R4 relocked by refresh key", d == 0, d, 0);
    wr(5'h00, 32'h5555);
    wr(5'h10, 32'h77); wait_idle(4, u);
    rd(5'h10, d); chk("R4 unlocked window write", d == 32'h77, d, 32'h77);
  endtask

  task automatic t_busy();
    logic [31:0] d;
    int u;
    do_reset();
    wr(5'h00, 32'h5555);
    wr(5'h04, 32'hFFFF_FFF3);
    rd(5'h0C, d); chk("R5 prescaler flag bit0 set", d == 1, d, 1);
    wait_idle(1, u); chk("R5 prescaler flag clears in 5", u <= 5, u, 5);
    rd(5'h04, d); chk("R3 prescaler readback", d == 3, d, 3);
    wr(5'h08, 32'hABC);
    rd(5'h0C, d); chk("R5 reload flag bit1 set", d == 2, d, 2);
    wait_idle(2, u); chk("R5 reload flag clears in 5", u <= 5, u, 5);
    rd(5'h08, d); chk("R3 reload readback", d == 32'hABC, d, 32'hABC);
    wr(5'h10, 32'h5A5);
    rd(5'h0C, d); chk("R5 window flag bit2 set", d == 4, d, 4);
    wait_idle(4, u); chk("R5 window flag clears in 5", u <= 5, u, 5);
    rd(5'h10, d); chk("R3 window readback", d == 32'h5A5, d, 32'h5A5);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d;
    int u;
    do_reset();
    wr(5'h00, 32'h5555);
    wr(5'h04, 2); wr(5'h04, 6);
    wait_idle(1, u);
    rd(5'h04, d); chk("R6 prescaler write while busy", d == 2, d, 2);
    wr(5'h08, 32'h111); wr(5'h08, 32'h222);
    wait_idle(2, u);
    rd(5'h08, d); chk("R6 reload write while busy", d == 32'h111, d, 32'h111);
  endtask

  task automatic t_timeout();
    int s0, n;
    do_reset();
    setup(0, 9, 32'hFFF);
    wr(5'h00, 32'hCCCC);
    s0 = scyc;
    wait_pulses(3, 400);
    chk("R8 three expiries seen", pulses >= 3, pulses, 3);
    chk("R7 first expiry after start", (ptime[0] - s0 >= 40) && (ptime[0] - s0 <= 48),
        ptime[0] - s0, 44);
    chk("R8 expiry interval", ptime[1] - ptime[0] == 40, ptime[1] - ptime[0], 40);
    chk("R8 expiry interval again", ptime[2] - ptime[1] == 40, ptime[2] - ptime[1], 40);
    chk("R8 pulse one slow cycle", wide == 0, wide, 0);
    wr(5'h00, 32'h0000); wr(5'h00, 32'h1234);
    n = pulses;
    repeat (100) @(posedge lsi_clk);
    chk("R7 watchdog cannot be stopped", pulses >= n + 2, pulses, n + 2);
  endtask

  task automatic t_divider(input int code, input int rl);
    logic [31:0] d;
    int exp;
    do_reset();
    setup(code, rl, 32'hFFF);
    rd(5'h04, d); chk("R3 prescaler code readback", d == code, d, code);
    wr(5'h00, 32'hCCCC);
    exp = (rl + 1) * period_of(code);
    wait_pulses(2, 3 * exp + 20);
    chk("R8 divider pulses seen", pulses >= 2, pulses, 2);
    chk("R8 divider interval", ptime[1] - ptime[0] == exp, ptime[1] - ptime[0], exp);
  endtask

  task automatic t_refresh_ok();
    do_reset();
    setup(0, 20, 10);
    wr(5'h00, 32'hCCCC);
    repeat (60) @(posedge lsi_clk);
    chk("R9 no pulse before refresh", pulses == 0, pulses, 0);
    wr(5'h00, 32'hAAAA);
    repeat (60) @(posedge lsi_clk);
    chk("R9 in-window refresh no pulse", pulses == 0, pulses, 0);
    repeat (40) @(posedge lsi_clk);
    chk("R9 counter reloaded then expires", pulses == 1, pulses, 1);
  endtask

  task automatic t_early();
    do_reset();
    setup(0, 100, 50);
    wr(5'h00, 32'hCCCC);
    repeat (20) @(posedge lsi_clk);
    chk("R10 no pulse before refresh", pulses == 0, pulses, 0);
    wr(5'h00, 32'hAAAA);
    repeat (8) @(posedge lsi_clk);
    chk("R10 early refresh pulses", pulses == 1, pulses, 1);
    repeat (150) @(posedge lsi_clk);
    chk("R10 early refresh reloads", pulses == 1, pulses, 1);
    chk("R10 pulse one slow cycle", wide == 0, wide, 0);
  endtask

  task automatic t_idle_refresh();
    do_reset();
    setup(0, 2, 32'hFFF);
    wr(5'h00, 32'hAAAA);
    repeat (100) @(posedge lsi_clk);
    chk("R11 refresh before start ignored", pulses == 0, pulses, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_protect();
    t_busy();
    t_busy_ignore();
    t_timeout();
    t_divider(7, 1);
    t_divider(2, 3);
    t_divider(6, 0);
    t_refresh_ok();
    t_early();
    t_idle_refresh();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule